// File: doc/BRIEF.md
# Dispatch Instruction Steering Unit

This unit sits at the front of the issue stage of an out-of-order core. Each cycle it may receive a group of up to `W` instruction slots from rename. For each slot it gets a valid bit and a set of type flags. It walks the slots from the lowest index upward and decides where each instruction goes. The choices are the normal issue queue, the non-speculative list of the issue queue, the load/store queue, or straight to completion for nops. It raises the matching insert strobes and the commit-ready and completion marks. The queues are outside this block; the unit only produces the per-slot strobes that drive their write ports.

The issue queue reports how many entries it has free. The unit subtracts the entries that earlier slots of the same group already claim. When a slot that needs a normal issue-queue entry finds none left, the unit stops the walk. It then requests a stall of the upstream stage, and the slots it did not take stay with rename for a later cycle. While the stage is recovering from a squash, no group is accepted. The group input is a valid/ready stream: `grp_ready` falls while `squashing` is high, and a group is taken only in a cycle with both `grp_valid` and `grp_ready` high. The result leaves on a registered output stream marked by `out_valid`. That stream has no ready, because the queues it writes cannot push back; full-queue back-pressure travels through `stall_req` instead.

Top module: `dsp_steer`

## Requirements
- R1: Slots are examined from index 0 upward, and the walk ends at the first slot whose valid bit is low; no slot at or above that index produces any strobe or is marked taken, even if its own valid bit is high.
- R2: A slot with the squashed flag (flag bit 0) is marked taken and produces no insert strobe and no mark of any kind.
- R3: A load (flag bit 1) raises the load/store-queue strobe and the normal issue-queue strobe for its slot.
- R4: A store (flag bit 2) raises the load/store-queue strobe, the non-speculative strobe and the commit-ready mark, and never the normal issue-queue strobe.
- R5: A non-speculative instruction (flag bit 3) raises the non-speculative strobe and the commit-ready mark only.
- R6: A nop (flag bit 4) raises the completion strobe (tail advance, issued and executed) and the commit-ready mark, and nothing else.
- R7: When a load or a plain instruction finds no free issue-queue entry, that slot gets no issue-queue strobe and is not taken, `stall_req` is raised, and every later slot is left untouched; a load stopped this way still raises its load/store-queue strobe.
- R8: While `squashing` is high, `grp_ready` is low and an offered group leaves no trace: `out_valid` and every strobe stay low in the following cycle.
- R9: The free count is reduced by each earlier slot of the same group that was inserted as a load, a plain instruction, a store or a non-speculative instruction; squashed slots and nops take no entry, and store and non-speculative inserts go ahead even with no entry free.
- R10: In each slot at most one of the normal issue-queue, non-speculative and completion strobes is high.
- R11: When several flags are set on one slot, squashed wins over load, load over store, store over non-speculative, and non-speculative over nop; a slot with no flag set is a plain instruction.
- R12: The outcome of a group accepted at one clock edge appears on the outputs, with `out_valid` high, right after the next edge, and groups may arrive on back-to-back cycles.
- R13: After reset `out_valid`, `stall_req` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| squashing | input | 1 | Stage is recovering from a squash; no group is taken |
| grp_valid | input | 1 | A dispatch group is offered |
| grp_ready | output | 1 | The unit can take the offered group |
| slot_vld | input | W | Per-slot valid bits |
| slot_flags | input | 5*W | Per-slot type flags, slot i at bits [5i+4:5i]: squashed, load, store, non-speculative, nop from bit 0 up |
| iq_free | input | FREE_W | Free entries in the issue queue at the start of the group |
| out_valid | output | 1 | The outputs below carry the result of one group |
| iq_ins | output | W | Normal issue-queue insert per slot |
| nsp_ins | output | W | Non-speculative list insert per slot |
| lsq_ins | output | W | Load/store-queue reserve per slot |
| nop_done | output | W | Tail advance with issued and executed marks per slot |
| commit_ok | output | W | Commit-ready mark per slot |
| taken | output | W | Slot fully dispatched and consumed from the group |
| stall_req | output | 1 | Issue queue ran out; upstream must stall and resend the untaken slots |

## Verification
On every cycle the assertions check the shape of each result: at most one issue-side target per slot, commit-ready only with a non-speculative insert or a nop, a taken mask that is a contiguous run from slot 0 covering only valid slots, and silence after a squashing cycle or when no result is flagged. Which target a given type reaches, the flag priority, and the point where the running free count stops the walk depend on the input mix. Only the bench scenarios show those, along with the unusual case of a load that reserves its load/store entry and still stalls. Back-to-back groups and the one-cycle result timing are likewise shown by the scoreboard, not by a property.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  localparam int FLAG_W   = 5;
  localparam int FB_SQSH  = 0;
  localparam int FB_LOAD  = 1;
  localparam int FB_STORE = 2;
  localparam int FB_NSPEC = 3;
  localparam int FB_NOP   = 4;

  typedef enum logic [2:0] {
    K_SKIP  = 3'd0,
    K_LOAD  = 3'd1,
    K_STORE = 3'd2,
    K_NSPEC = 3'd3,
    K_NOP   = 3'd4,
    K_PLAIN = 3'd5
  } kind_e;

endpackage

// File: rtl/dsp_classify.sv
module dsp_classify
  import dsp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W*FLAG_W-1:0] flags,
  output kind_e               kind [W]
);

  for (genvar s = 0; s < W; s++) begin : g_slot
    logic [FLAG_W-1:0] f;
    assign f = flags[s*FLAG_W +: FLAG_W];

    always_comb begin
      if      (f[FB_SQSH])  kind[s] = K_SKIP;
      else if (f[FB_LOAD])  kind[s] = K_LOAD;
      else if (f[FB_STORE]) kind[s] = K_STORE;
      else if (f[FB_NSPEC]) kind[s] = K_NSPEC;
      else if (f[FB_NOP])   kind[s] = K_NOP;
      else                  kind[s] = K_PLAIN;
    end
  end

endmodule

// File: rtl/dsp_scan.sv
module dsp_scan
  import dsp_pkg::*;
#(
  parameter int W        = 4,
  parameter int IQ_DEPTH = 16,
  parameter int FREE_W   = $clog2(IQ_DEPTH + 1)
) (
  input  logic              en,
  input  logic [W-1:0]      slot_vld,
  input  kind_e             kind [W],
  input  logic [FREE_W-1:0] iq_free,
  output logic [W-1:0]      iq_o,
  output logic [W-1:0]      nsp_o,
  output logic [W-1:0]      lsq_o,
  output logic [W-1:0]      nop_o,
  output logic [W-1:0]      cmt_o,
  output logic [W-1:0]      tk_o,
  output logic              stall_o
);

  localparam int CW = $clog2(IQ_DEPTH + W + 1) + 1;

  logic [CW-1:0] free_x;
  assign free_x = {{(CW-FREE_W){1'b0}}, iq_free};

  logic [CW-1:0] used;
  logic          alive;
  logic          full;

  always_comb begin
    iq_o    = '0;
    nsp_o   = '0;
    lsq_o   = '0;
    nop_o   = '0;
    cmt_o   = '0;
    tk_o    = '0;
    stall_o = 1'b0;
    alive   = en;
    used    = '0;
    full    = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (alive) begin
        if (!slot_vld[i]) begin
          alive = 1'b0;
        end else begin
          full = (used >= free_x);
          case (kind[i])
            K_SKIP: tk_o[i] = 1'b1;
            K_LOAD: begin
              lsq_o[i] = 1'b1;
              if (full) begin
                stall_o = 1'b1;
                alive   = 1'b0;
              end else begin
                iq_o[i] = 1'b1;
                tk_o[i] = 1'b1;
                used    = used + CW'(1);
              end
            end
            K_STORE: begin
              lsq_o[i] = 1'b1;
              nsp_o[i] = 1'b1;
              cmt_o[i] = 1'b1;
              tk_o[i]  = 1'b1;
              used     = used + CW'(1);
            end
            K_NSPEC: begin
              nsp_o[i] = 1'b1;
              cmt_o[i] = 1'b1;
              tk_o[i]  = 1'b1;
              used     = used + CW'(1);
            end
            K_NOP: begin
              nop_o[i] = 1'b1;
              cmt_o[i] = 1'b1;
              tk_o[i]  = 1'b1;
            end
            default: begin
              if (full) begin
                stall_o = 1'b1;
                alive   = 1'b0;
              end else begin
                iq_o[i] = 1'b1;
                tk_o[i] = 1'b1;
                used    = used + CW'(1);
              end
            end
          endcase
        end
      end
    end
  end

  // R9: a normal insert never exceeds the entries free at group start
  always_comb begin
    if (en) begin
      p_iq_cap_r9: assert ($countones(iq_o) <= int'(iq_free) || $countones(iq_o) == 0);
    end
  end

endmodule

// File: rtl/dsp_steer.sv
module dsp_steer
  import dsp_pkg::*;
#(
  parameter int W        = 4,
  parameter int IQ_DEPTH = 16,
  parameter int FREE_W   = $clog2(IQ_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                squashing,
  input  logic                grp_valid,
  output logic                grp_ready,
  input  logic [W-1:0]        slot_vld,
  input  logic [W*FLAG_W-1:0] slot_flags,
  input  logic [FREE_W-1:0]   iq_free,
  output logic                out_valid,
  output logic [W-1:0]        iq_ins,
  output logic [W-1:0]        nsp_ins,
  output logic [W-1:0]        lsq_ins,
  output logic [W-1:0]        nop_done,
  output logic [W-1:0]        commit_ok,
  output logic [W-1:0]        taken,
  output logic                stall_req
);

  kind_e        kind [W];
  logic         accept;
  logic [W-1:0] c_iq, c_nsp, c_lsq, c_nop, c_cmt, c_tk;
  logic         c_stall;

  assign grp_ready = !squashing;
  assign accept    = grp_valid && grp_ready;

  dsp_classify #(.W(W)) u_cls (
    .flags (slot_flags),
    .kind  (kind)
  );

  dsp_scan #(.W(W), .IQ_DEPTH(IQ_DEPTH), .FREE_W(FREE_W)) u_scan (
    .en       (accept),
    .slot_vld (slot_vld),
    .kind     (kind),
    .iq_free  (iq_free),
    .iq_o     (c_iq),
    .nsp_o    (c_nsp),
    .lsq_o    (c_lsq),
    .nop_o    (c_nop),
    .cmt_o    (c_cmt),
    .tk_o     (c_tk),
    .stall_o  (c_stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      iq_ins    <= '0;
      nsp_ins   <= '0;
      lsq_ins   <= '0;
      nop_done  <= '0;
      commit_ok <= '0;
      taken     <= '0;
      stall_req <= 1'b0;
    end else begin
      out_valid <= accept;
      iq_ins    <= c_iq;
      nsp_ins   <= c_nsp;
      lsq_ins   <= c_lsq;
      nop_done  <= c_nop;
      commit_ok <= c_cmt;
      taken     <= c_tk;
      stall_req <= c_stall;
    end
  end

  // R8: a squashing cycle leaves no result behind
  p_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(squashing) |-> !out_valid);

  // R8: no strobe without a result
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ((iq_ins | nsp_ins | lsq_ins | nop_done | commit_ok | taken) == '0 && !stall_req));

  // R1: only slots that were valid can be taken
  p_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((taken & ~$past(slot_vld)) == '0));

  // R7: a stall comes with a result
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> out_valid);

  for (genvar s = 0; s < W; s++) begin : g_chk
    // R10: one issue-side target per slot
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({iq_ins[s], nsp_ins[s], nop_done[s]}));
    // R4: commit-ready only with non-speculative insert or nop
    p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_ok[s] |-> (nsp_ins[s] || nop_done[s]));
    // R3: a load/store reservation never pairs with a nop completion
    p_lsq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lsq_ins[s] |-> !nop_done[s]);
    if (s > 0) begin : g_ord
      // R1: taken slots form a run starting at slot 0
      p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        taken[s] |-> taken[s-1]);
    end
  end

endmodule

// File: tb/tb_dsp_steer.sv
`timescale 1ns/1ps
module tb_dsp_steer;

  localparam int W = 4;
  localparam int D = 16;
  localparam int FW = $clog2(D + 1);

  typedef struct packed {
    logic [W-1:0] iq, nsp, lsq, nop, cmt, tk;
    logic         stall;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic squashing = 1'b0;
  logic grp_valid = 1'b0;
  logic grp_ready;
  logic [W-1:0] slot_vld = '0;
  logic [W*5-1:0] slot_flags = '0;
  logic [FW-1:0] iq_free = '0;
  logic out_valid;
  logic [W-1:0] iq_ins, nsp_ins, lsq_ins, nop_done, commit_ok, taken;
  logic stall_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  dsp_steer #(.W(W), .IQ_DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .squashing(squashing),
    .grp_valid(grp_valid), .grp_ready(grp_ready),
    .slot_vld(slot_vld), .slot_flags(slot_flags), .iq_free(iq_free),
    .out_valid(out_valid), .iq_ins(iq_ins), .nsp_ins(nsp_ins),
    .lsq_ins(lsq_ins), .nop_done(nop_done), .commit_ok(commit_ok),
    .taken(taken), .stall_req(stall_req)
  );

  // flag bits: 0 squashed, 1 load, 2 store, 3 non-speculative, 4 nop
  localparam logic [4:0] F_PL = 5'b00000;
  localparam logic [4:0] F_SQ = 5'b00001;
  localparam logic [4:0] F_LD = 5'b00010;
  localparam logic [4:0] F_ST = 5'b00100;
  localparam logic [4:0] F_NS = 5'b01000;
  localparam logic [4:0] F_NP = 5'b10000;

  function automatic exp_t model(logic [W-1:0] v, logic [W*5-1:0] f, int free);
    exp_t e = '0;
    int used = 0;
    for (int i = 0; i < W; i++) begin
      logic [4:0] x;
      if (!v[i]) break;
      x = f[i*5 +: 5];
      if (x[0]) e.tk[i] = 1'b1;
      else if (x[1]) begin
        e.lsq[i] = 1'b1;
        if (used >= free) begin e.stall = 1'b1; break; end
        e.iq[i] = 1'b1; e.tk[i] = 1'b1; used++;
      end else if (x[2]) begin
        e.lsq[i] = 1'b1; e.nsp[i] = 1'b1; e.cmt[i] = 1'b1; e.tk[i] = 1'b1; used++;
      end else if (x[3]) begin
        e.nsp[i] = 1'b1; e.cmt[i] = 1'b1; e.tk[i] = 1'b1; used++;
      end else if (x[4]) begin
        e.nop[i] = 1'b1; e.cmt[i] = 1'b1; e.tk[i] = 1'b1;
      end else begin
        if (used >= free) begin e.stall = 1'b1; break; end
        e.iq[i] = 1'b1; e.tk[i] = 1'b1; used++;
      end
    end
    return e;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // driver: offers one group for one cycle and queues its expected result
  task automatic send(string req, logic [W-1:0] v, logic [4:0] f0, logic [4:0] f1,
                      logic [4:0] f2, logic [4:0] f3, int free, logic sq);
    slot_vld   = v;
    slot_flags = {f3, f2, f1, f0};
    iq_free    = FW'(free);
    squashing  = sq;
    grp_valid  = 1'b1;
    if (!sq) begin
      exp_q.push_back(model(v, {f3, f2, f1, f0}, free));
      tag_q.push_back(req);
    end
    @(negedge clk);
    grp_valid = 1'b0;
    squashing = 1'b0;
  endtask

  // monitor: compares every produced result against the queue front
  always @(negedge clk) begin
    if (rst_n && !finished && out_valid) begin
      exp_t a;
      a = '{iq: iq_ins, nsp: nsp_ins, lsq: lsq_ins, nop: nop_done,
            cmt: commit_ok, tk: taken, stall: stall_req};
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 actual=%h expected=no result", a);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'(a), 64'(e));
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", 64'({out_valid, stall_req, iq_ins, nsp_ins, lsq_ins, nop_done, commit_ok, taken}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", 64'({out_valid, stall_req}), 64'(0));

    send("R12", 4'b1111, F_PL, F_PL, F_PL, F_PL, 16, 1'b0);           // all plain
    send("R3",  4'b1111, F_LD, F_ST, F_NS, F_NP, 16, 1'b0);           // R3 R4 R5 R6 mix
    send("R1",  4'b1011, F_PL, F_PL, F_PL, F_PL, 16, 1'b0);           // gap at slot 2
    send("R2",  4'b0111, F_SQ, F_PL, F_SQ, F_PL, 16, 1'b0);           // squashed skipped
    send("R7",  4'b1111, F_PL, F_PL, F_PL, F_PL, 2, 1'b0);            // runs out at slot 2
    send("R9",  4'b1111, F_ST, F_PL, F_PL, F_PL, 1, 1'b0);            // store eats the last entry
    send("R7",  4'b1111, F_NP, F_SQ, F_LD, F_PL, 0, 1'b0);            // load stalls but reserves
    send("R9",  4'b1111, F_ST, F_NS, F_NP, F_SQ, 0, 1'b0);            // nonspec inserts with none free
    send("R11", 4'b1111, F_SQ | F_LD, F_LD | F_ST, F_NS | F_NP, F_ST | F_NS, 16, 1'b0);
    send("R6",  4'b0001, F_NP, F_PL, F_PL, F_PL, 0, 1'b0);            // lone nop with full queue
    send("R4",  4'b1111, F_ST, F_ST, F_ST, F_ST, 16, 1'b0);
    send("R1",  4'b1110, F_PL, F_PL, F_PL, F_PL, 16, 1'b0);           // slot 0 invalid
    @(negedge clk);

    // R8: a group offered while squashing
    slot_vld = 4'b1111; slot_flags = '0; iq_free = FW'(16);
    squashing = 1'b1; grp_valid = 1'b1;
    #1;
    chk("R8", 64'(grp_ready), 64'(0));
    @(negedge clk);
    grp_valid = 1'b0; squashing = 1'b0;
    chk("R8", 64'({out_valid, stall_req, iq_ins, nsp_ins, lsq_ins, nop_done, commit_ok, taken}), 64'(0));

    send("R5",  4'b0011, F_NS, F_PL, F_PL, F_PL, 1, 1'b0);            // nonspec then plain stalls
    @(negedge clk);
    @(negedge clk);
    chk("R12", 64'(exp_q.size()), 64'(0));
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule